// File: doc/BRIEF.md
# Serial Command Front End for a 16-Channel Output Controller

This block is the serial slave side of a multi-channel low-side output controller. A host drives an active-low select, a serial clock and a data line. The block answers on a data output that it enables only while it is selected. Every transfer is a 24-bit word, sent and received most significant bit first.

When select goes low, the block captures a status word from the separate fault manager and shifts it out. While selected, it shifts the host's bits in. When select goes high, the block decodes the last 24 bits it received and writes one of its control registers:

- the per-output on/off pattern
- the open-load pull-down enables
- the short-fault protection mode
- the PWM enables
- the PWM AND/OR select
- the two global recovery flags

Bits shifted in keep flowing out of the data output after the status bits. A 48-bit transfer therefore returns the status and then the first 24 bits written, which supports daisy chains and bus integrity checks.

All serial inputs cross into the system clock domain through synchronizer chains. Edges are found by oversampling, so the system clock must run several times faster than the serial clock.

Top module: `spi_cmd_frontend`

## Requirements
- R1: After rst_n is released, every control output (drv_on, ld_olen, sfp_mode, pwm_sel, pwm_or, ov_retry, th_retry) is zero and sdo_oe is low.
- R2: sdi is sampled on each falling edge of sclk while cs_n is low, and the received word is taken MSB first.
- R3: While cs_n is high, sdo_oe is low and activity on sclk and sdi changes no state.
- R4: On the falling edge of cs_n the block captures a status word and shifts it out MSB first, presenting each bit after a rising edge of sclk. The word is laid out as follows:
  - bit 23 is any-fault (flt_ov OR any flt_out bit)
  - bit 22 is flt_ov
  - bits 21..16 are zero
  - bits 15..0 are flt_out[15..0]
- R5: A command takes effect only on the rising edge of cs_n. Bits 23..18 hold the opcode and bits 15..0 the per-output data. The opcodes are:
  - 0: drv_on
  - 1: ld_olen
  - 3: sfp_mode
  - 4: pwm_sel
  - 5: pwm_or
- R6: Opcode 2 writes the global recovery flags: bit 16 goes to ov_retry and bit 17 to th_retry.
- R7: Opcode 6 clears every control output to zero.
- R8: Asserting rst_n low clears every control output, even after registers were written.
- R9: Opcodes 7 to 63 leave every control output unchanged.
- R10: After the 24 status bits, sdo returns the bits received on sdi delayed by 24 clocks. For a longer transfer, only the last 24 bits received are decoded.
- R11: Changes on flt_ov or flt_out after cs_n falls do not alter the status word being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, must run well above the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset for all registers |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| flt_ov | input | 1 | Overvoltage flag from the fault manager |
| flt_out | input | 16 | Per-output fault flags from the fault manager |
| drv_on | output | 16 | Commanded on/off state per output |
| ld_olen | output | 16 | Open-load pull-down enable per output |
| sfp_mode | output | 16 | Short-fault protection mode per output (1 = thermal only) |
| pwm_sel | output | 16 | Per-output PWM enable |
| pwm_or | output | 16 | Per-output PWM combine select (0 = AND, 1 = OR) |
| ov_retry | output | 1 | Resume after overvoltage (1) or stay off (0) |
| th_retry | output | 1 | Retry after thermal shutdown (1) or stay off (0) |

## Verification
Assertions check several properties on every cycle:
- the shift register captures the status word exactly one cycle after a detected select fall
- the shift register holds still while select is high
- each detected serial clock fall moves the synchronized data bit into bit 0
- the control registers change only at a detected select rise
- the reset opcode empties the registers
- unknown opcodes leave the registers untouched
- the global flags come from bits 16 and 17

Other behaviour can only be shown by the bench's scenarios, which run whole transfers at the pins:
- the MSB-first word order
- the exact bit layout of the status word
- the delayed echo in long transfers
- the decoding of only the final word
- the freezing of the status word against late fault changes

// File: rtl/sfe_pkg.sv
package sfe_pkg;
   localparam int OPC_W = 6;
   localparam int HDR_W = 8;

   typedef enum logic [OPC_W-1:0] {
      OP_ONOFF  = 6'd0,
      OP_OLEN   = 6'd1,
      OP_GLOBAL = 6'd2,
      OP_SFPD   = 6'd3,
      OP_PWMEN  = 6'd4,
      OP_ANDOR  = 6'd5,
      OP_RESET  = 6'd6
   } sfe_op_e;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sfe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/sfe_shifter.sv
module sfe_shifter #(
   parameter int FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_lvl,
   input  logic               cs_fall,
   input  logic               sclk_rise,
   input  logic               sclk_fall,
   input  logic               sdi_lvl,
   input  logic [FRAME_W-1:0] status,
   output logic [FRAME_W-1:0] frame,
   output logic               sdo,
   output logic               sdo_oe
);
   localparam int MSB = FRAME_W - 1;

   logic [FRAME_W-1:0] sr;
   logic               so_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr   <= '0;
         so_q <= 1'b0;
      end else if (cs_fall) begin
         sr   <= status;
         so_q <= status[MSB];
      end else if (!cs_lvl) begin
         if (sclk_rise) so_q <= sr[MSB];
         if (sclk_fall) sr   <= {sr[MSB-1:0], sdi_lvl};
      end
   end

   assign frame  = sr;
   assign sdo    = so_q;
   assign sdo_oe = ~cs_lvl;

   a_r4_status_load: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (sr == $past(status)));
   a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      cs_lvl |=> $stable(sr));
   a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_lvl && !cs_fall && sclk_fall) |=> (sr[0] == $past(sdi_lvl)));
endmodule

// File: rtl/sfe_regfile.sv
module sfe_regfile
   import sfe_pkg::*;
#(
   parameter int N_OUT   = 16,
   parameter int FRAME_W = N_OUT + HDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs_rise,
   input  logic [FRAME_W-1:0] frame,
   output logic [N_OUT-1:0]   drv_on,
   output logic [N_OUT-1:0]   ld_olen,
   output logic [N_OUT-1:0]   sfp_mode,
   output logic [N_OUT-1:0]   pwm_sel,
   output logic [N_OUT-1:0]   pwm_or,
   output logic               ov_retry,
   output logic               th_retry
);
   generate
      if (FRAME_W != N_OUT + HDR_W) begin : g_bad
         $error("sfe_regfile: FRAME_W must equal N_OUT + HDR_W");
      end
   endgenerate

   logic [OPC_W-1:0] op;
   logic [N_OUT-1:0] data;

   assign op   = frame[FRAME_W-1 -: OPC_W];
   assign data = frame[N_OUT-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_on   <= '0;
         ld_olen  <= '0;
         sfp_mode <= '0;
         pwm_sel  <= '0;
         pwm_or   <= '0;
         ov_retry <= 1'b0;
         th_retry <= 1'b0;
      end else if (cs_rise) begin
         case (op)
            OP_ONOFF:  drv_on   <= data;
            OP_OLEN:   ld_olen  <= data;
            OP_SFPD:   sfp_mode <= data;
            OP_PWMEN:  pwm_sel  <= data;
            OP_ANDOR:  pwm_or   <= data;
            OP_GLOBAL: begin
               ov_retry <= frame[N_OUT];
               th_retry <= frame[N_OUT+1];
            end
            OP_RESET: begin
               drv_on   <= '0;
               ld_olen  <= '0;
               sfp_mode <= '0;
               pwm_sel  <= '0;
               pwm_or   <= '0;
               ov_retry <= 1'b0;
               th_retry <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   logic [5*N_OUT+1:0] all_regs;
   assign all_regs = {drv_on, ld_olen, sfp_mode, pwm_sel, pwm_or, ov_retry, th_retry};

   a_r5_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_rise |=> $stable(all_regs));
   a_r7_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && op == OP_RESET) |=> (all_regs == '0));
   a_r9_unknown_op: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && op > OP_RESET) |=> $stable(all_regs));
   a_r6_global_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_rise && op == OP_GLOBAL) |=>
         (ov_retry == $past(frame[N_OUT]) && th_retry == $past(frame[N_OUT+1])));
endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend
   import sfe_pkg::*;
#(
   parameter int N_OUT       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic             sdi,
   output logic             sdo,
   output logic             sdo_oe,
   input  logic             flt_ov,
   input  logic [N_OUT-1:0] flt_out,
   output logic [N_OUT-1:0] drv_on,
   output logic [N_OUT-1:0] ld_olen,
   output logic [N_OUT-1:0] sfp_mode,
   output logic [N_OUT-1:0] pwm_sel,
   output logic [N_OUT-1:0] pwm_or,
   output logic             ov_retry,
   output logic             th_retry
);
   localparam int FRAME_W = N_OUT + HDR_W;
   localparam int PAD_W   = HDR_W - 2;

   generate
      if (N_OUT < 2) begin : g_bad
         $error("spi_cmd_frontend: N_OUT must be at least 2");
      end
   endgenerate

   logic [2:0] pins_s;
   logic       cs_s, sclk_s, sdi_s;
   logic       cs_prev, sclk_prev;
   logic       cs_fall, cs_rise, sclk_rise, sclk_fall;

   sfe_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({cs_n, sclk, sdi}),
      .dout (pins_s)
   );

   assign {cs_s, sclk_s, sdi_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev   <= 1'b1;
         sclk_prev <= 1'b0;
      end else begin
         cs_prev   <= cs_s;
         sclk_prev <= sclk_s;
      end
   end

   assign cs_fall   =  cs_prev & ~cs_s;
   assign cs_rise   = ~cs_prev &  cs_s;
   assign sclk_rise = ~sclk_prev &  sclk_s;
   assign sclk_fall =  sclk_prev & ~sclk_s;

   logic [FRAME_W-1:0] status;
   logic [FRAME_W-1:0] frame;

   assign status = {(flt_ov | (|flt_out)), flt_ov, {PAD_W{1'b0}}, flt_out};

   sfe_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_lvl   (cs_s),
      .cs_fall  (cs_fall),
      .sclk_rise(sclk_rise),
      .sclk_fall(sclk_fall),
      .sdi_lvl  (sdi_s),
      .status   (status),
      .frame    (frame),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe)
   );

   sfe_regfile #(.N_OUT(N_OUT), .FRAME_W(FRAME_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_rise (cs_rise),
      .frame   (frame),
      .drv_on  (drv_on),
      .ld_olen (ld_olen),
      .sfp_mode(sfp_mode),
      .pwm_sel (pwm_sel),
      .pwm_or  (pwm_or),
      .ov_retry(ov_retry),
      .th_retry(th_retry)
   );

   a_r3_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_prev && cs_s) |-> (sdo_oe == 1'b0));
endmodule

// File: tb/spi_cmd_frontend_tb.sv
`timescale 1ns/1ps
module spi_cmd_frontend_tb;
   localparam int HALF = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        sdi = 1'b0;
   logic        sdo, sdo_oe;
   logic        flt_ov = 1'b0;
   logic [15:0] flt_out = '0;
   logic [15:0] drv_on, ld_olen, sfp_mode, pwm_sel, pwm_or;
   logic        ov_retry, th_retry;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] e_on = '0, e_ol = '0, e_sf = '0, e_pw = '0, e_or = '0;
   logic        e_ov = 1'b0, e_th = 1'b0;

   always #10 clk = ~clk;

   spi_cmd_frontend u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
      .sdo(sdo), .sdo_oe(sdo_oe), .flt_ov(flt_ov), .flt_out(flt_out),
      .drv_on(drv_on), .ld_olen(ld_olen), .sfp_mode(sfp_mode),
      .pwm_sel(pwm_sel), .pwm_or(pwm_or), .ov_retry(ov_retry), .th_retry(th_retry)
   );

   task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic chk_regs(input string tag);
      chk({tag, " drv_on"},   48'(drv_on),   48'(e_on));
      chk({tag, " ld_olen"},  48'(ld_olen),  48'(e_ol));
      chk({tag, " sfp_mode"}, 48'(sfp_mode), 48'(e_sf));
      chk({tag, " pwm_sel"},  48'(pwm_sel),  48'(e_pw));
      chk({tag, " pwm_or"},   48'(pwm_or),   48'(e_or));
      chk({tag, " retry"},    48'({ov_retry, th_retry}), 48'({e_ov, e_th}));
   endtask

   function automatic logic [23:0] stat_word(input logic ov, input logic [15:0] f);
      return {(ov | (|f)), ov, 6'b0, f};
   endfunction

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame_begin();
      @(negedge clk);
      cs_n = 1'b0;
      wait_clk(HALF);
   endtask

   task automatic shift_bits(input logic [47:0] d, input int n, output logic [47:0] r);
      r = '0;
      for (int i = n - 1; i >= 0; i--) begin
         sdi  = d[i];
         sclk = 1'b1;
         wait_clk(HALF);
         r[i] = sdo;
         sclk = 1'b0;
         wait_clk(HALF);
      end
   endtask

   task automatic frame_end();
      cs_n = 1'b1;
      wait_clk(2 * HALF);
   endtask

   task automatic xfer(input logic [47:0] d, input int n, output logic [47:0] r);
      frame_begin();
      shift_bits(d, n, r);
      frame_end();
   endtask

   task automatic t_reset_state();
      chk_regs("R1 reset");
      chk("R1 R3 sdo_oe idle", 48'(sdo_oe), 48'(0));
   endtask

   task automatic t_onoff_and_status();
      logic [47:0] r;
      flt_ov = 1'b0; flt_out = 16'h8001;
      xfer(48'h00A5C3, 24, r);
      e_on = 16'hA5C3;
      chk("R4 status word", r[23:0], 48'(stat_word(1'b0, 16'h8001)));
      chk_regs("R2 R5 on/off write");
      flt_ov = 1'b1; flt_out = 16'h0000;
      xfer(48'h005A3C, 24, r);
      e_on = 16'h5A3C;
      chk("R4 overvoltage status", r[23:0], 48'(stat_word(1'b1, 16'h0000)));
      chk_regs("R2 on/off second write");
      flt_ov = 1'b0;
   endtask

   task automatic t_decode_at_rise();
      logic [47:0] r;
      frame_begin();
      chk("R3 sdo_oe active", 48'(sdo_oe), 48'(1));
      shift_bits(48'h00FFFF, 24, r);
      wait_clk(2 * HALF);
      chk_regs("R5 no update before cs rise");
      frame_end();
      e_on = 16'hFFFF;
      chk_regs("R5 update at cs rise");
   endtask

   task automatic t_each_register();
      logic [47:0] r;
      xfer(48'h041111, 24, r); e_ol = 16'h1111;
      xfer(48'h0C2222, 24, r); e_sf = 16'h2222;
      xfer(48'h103333, 24, r); e_pw = 16'h3333;
      xfer(48'h144444, 24, r); e_or = 16'h4444;
      chk_regs("R5 per-register opcodes");
   endtask

   task automatic t_global();
      logic [47:0] r;
      xfer(48'h0A0000, 24, r); e_th = 1'b1; e_ov = 1'b0;
      chk_regs("R6 thermal bit17");
      xfer(48'h09FFFF, 24, r); e_th = 1'b0; e_ov = 1'b1;
      chk_regs("R6 overvoltage bit16");
   endtask

   task automatic t_unknown_ops();
      logic [47:0] r;
      xfer(48'h1C0000, 24, r);
      xfer(48'hFCFFFF, 24, r);
      xfer(48'h200F0F, 24, r);
      chk_regs("R9 unknown opcodes ignored");
   endtask

   task automatic t_cs_high_ignored();
      logic [47:0] r;
      for (int i = 0; i < 30; i++) begin
         sdi  = i[0];
         sclk = ~sclk;
         wait_clk(HALF);
      end
      sclk = 1'b0;
      wait_clk(HALF);
      chk("R3 sdo_oe while deselected", 48'(sdo_oe), 48'(0));
      chk_regs("R3 clocks ignored while deselected");
      flt_out = 16'h0240;
      xfer(48'h1CAAAA, 24, r);
      chk("R3 status unaffected by idle clocks", r[23:0], 48'(stat_word(1'b0, 16'h0240)));
   endtask

   task automatic t_status_frozen();
      logic [47:0] r;
      flt_ov = 1'b0; flt_out = 16'h1234;
      frame_begin();
      flt_ov = 1'b1; flt_out = 16'hFFFF;
      shift_bits(48'h1C0000, 24, r);
      frame_end();
      chk("R11 status frozen at cs fall", r[23:0], 48'(stat_word(1'b0, 16'h1234)));
      flt_ov = 1'b0; flt_out = '0;
   endtask

   task automatic t_daisy();
      logic [47:0] r;
      xfer(48'h101234_00BEEF, 48, r);
      e_on = 16'hBEEF;
      chk("R10 echo of first word", r[23:0], 48'h101234);
      chk("R10 status in front", 48'(r[47:24]), 48'(stat_word(1'b0, 16'h0000)));
      chk_regs("R10 only last word decoded");
   endtask

   task automatic t_soft_reset();
      logic [47:0] r;
      xfer(48'h18FFFF, 24, r);
      e_on = '0; e_ol = '0; e_sf = '0; e_pw = '0; e_or = '0; e_ov = 1'b0; e_th = 1'b0;
      chk_regs("R7 reset opcode");
   endtask

   task automatic t_pin_reset();
      logic [47:0] r;
      xfer(48'h00C0DE, 24, r);
      xfer(48'h107777, 24, r);
      xfer(48'h0B0000, 24, r);
      e_on = 16'hC0DE; e_pw = 16'h7777; e_ov = 1'b1; e_th = 1'b1;
      chk_regs("R8 before reset pin");
      @(negedge clk); rst_n = 1'b0;
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(4);
      e_on = '0; e_pw = '0; e_ov = 1'b0; e_th = 1'b0;
      chk_regs("R8 reset pin clears");
   endtask

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      t_reset_state();
      t_onoff_and_status();
      t_decode_at_rise();
      t_each_register();
      t_global();
      t_unknown_ops();
      t_cs_high_ignored();
      t_status_frozen();
      t_daisy();
      t_soft_reset();
      t_pin_reset();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule